// File: doc/BRIEF.md
# Three-wire display command receiver

This block takes write-only commands for a multiplexed display controller over three wires: a chip-select, a shift clock and a data line. The three wires are brought into the system clock domain through two-flop synchronisers. Each rising edge of the shift clock seen while chip-select is high captures one data bit. When chip-select goes low, the block reads the last three bits received as a mode code and commits the frame to its storage.

The frame length depends on the mode. A segment frame is 35 bits long: 32 segment bits, the first bit lighting segment 1, followed by three mode bits. A dimming frame is 13 bits long: a 10-bit brightness value sent least significant bit first, followed by the same three-bit mode field. One mode code broadcasts a segment word to all three grid latches. Three other codes each target a single grid. Any frame whose length does not fit its code, and any unused code, is dropped without changing storage. The outputs feed the grid scanner and the brightness modulator directly.

Top module: `dispcmd_rx`

## Requirements
- R1: Reset clears the three segment words and the dimming word to zero, along with the bit counter and the shift register.
- R2: A bit is captured only on a rising edge of the synchronised shift clock while chip-select is high. Shift-clock edges while chip-select is low change nothing.
- R3: A 35-bit frame with mode {M2,M1,M0}=000 writes its segment word into all three grid words. The first bit of the frame lands in bit 0 (segment 1), and the 32nd bit lands in bit 31.
- R4: A 35-bit frame with mode 001, 010 or 011 writes only the grid 1, grid 2 or grid 3 word respectively.
- R5: A 13-bit frame with mode 100 writes the dimming word, with the first bit as bit 0 and the tenth bit as bit 9. The segment words are left unchanged.
- R6: Storage changes only on the falling edge of chip-select. Bits already shifted in have no effect while chip-select stays high.
- R7: A frame whose bit count is not 35 for modes 000 to 011, or not 13 for mode 100, is discarded and leaves all outputs unchanged.
- R8: Mode codes 101, 110 and 111 are discarded and leave all outputs unchanged.
- R9: A rising edge of chip-select restarts the bit count, so bits from an earlier window never count toward a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Asynchronous chip-select, high opens a frame |
| sclk_i | input | 1 | Asynchronous shift clock |
| sdata_i | input | 1 | Asynchronous serial data |
| grid1_seg_o | output | 32 | Segment word for grid 1, bit n lights segment n+1 |
| grid2_seg_o | output | 32 | Segment word for grid 2 |
| grid3_seg_o | output | 32 | Segment word for grid 3 |
| dim_o | output | 10 | Dimming value |

## Verification
A wrong bit counter or a misaligned shift register shows up at the ports as soon as chip-select has dropped three system clocks later. Either a valid frame fails to load, or a discarded frame loads, or the word appears bit-reversed or shifted by one. A wrong mode decode shows up as a neighbouring grid word changing or the dimming word being hit. Because storage only moves at a chip-select fall, every such fault is visible from the next frame boundary on and stays visible until the next write to the same word.

// File: rtl/dispcmd_rx_pkg.sv
package dispcmd_rx_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_ALL  = 3'b000,
        MODE_G1   = 3'b001,
        MODE_G2   = 3'b010,
        MODE_G3   = 3'b011,
        MODE_DIM  = 3'b100
    } mode_e;

endpackage

// File: rtl/cmd_sync.sv
module cmd_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter #(
    parameter int FRAME_W = 35,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_s,
    input  logic               sclk_s,
    input  logic               sdata_s,
    output logic               load_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [FRAME_W-1:0] sr_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               cs_prev;
        logic               sclk_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sr;
    } state_t;

    state_t st_d, st_q;
    logic   cs_rise, cs_fall, sclk_rise;

    always_comb begin
        cs_rise   = cs_s && !st_q.cs_prev;
        cs_fall   = !cs_s && st_q.cs_prev;
        sclk_rise = sclk_s && !st_q.sclk_prev;
        st_d = st_q;
        st_d.cs_prev   = cs_s;
        st_d.sclk_prev = sclk_s;
        if (cs_rise) begin
            st_d.cnt = '0;
        end else if (cs_s && sclk_rise) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], sdata_s};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load_o = cs_fall;
    assign cnt_o  = st_q.cnt;
    assign sr_o   = st_q.sr;

    // R2: with chip-select low nothing is captured
    assert_cs_low_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> ($stable(cnt_o) && $stable(sr_o)));

    // R2: each captured edge advances the count by one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_s && st_q.cs_prev && sclk_s && !st_q.sclk_prev && cnt_o != CNT_MAX)
        |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R9: a new window starts the count from zero
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (cs_s && !st_q.cs_prev) |=> (cnt_o == '0));
endmodule

// File: rtl/cmd_latch_bank.sv
module cmd_latch_bank
    import dispcmd_rx_pkg::*;
#(
    parameter int SEG_W     = 32,
    parameter int DIM_W     = 10,
    parameter int NUM_GRIDS = 3,
    parameter int FRAME_W   = SEG_W + MODE_W,
    parameter int CNT_W     = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load_i,
    input  logic [CNT_W-1:0]                    cnt_i,
    input  logic [FRAME_W-1:0]                  sr_i,
    output logic [NUM_GRIDS-1:0][SEG_W-1:0]     seg_o,
    output logic [DIM_W-1:0]                    dim_o
);
    localparam logic [CNT_W-1:0] SEG_LEN = CNT_W'(SEG_W + MODE_W);
    localparam logic [CNT_W-1:0] DIM_LEN = CNT_W'(DIM_W + MODE_W);

    typedef struct packed {
        logic [NUM_GRIDS-1:0][SEG_W-1:0] seg;
        logic [DIM_W-1:0]                dim;
    } state_t;

    state_t                st_d, st_q;
    logic [MODE_W-1:0]     mode;
    logic [SEG_W-1:0]      seg_word;
    logic [DIM_W-1:0]      dim_word;
    logic [NUM_GRIDS-1:0]  wr_grid;
    logic                  wr_dim;

    // last bit received is the top mode bit, so reverse the low bits
    always_comb begin
        for (int k = 0; k < MODE_W; k++) mode[k] = sr_i[MODE_W-1-k];
        for (int i = 0; i < SEG_W; i++)  seg_word[i] = sr_i[MODE_W+SEG_W-1-i];
        for (int i = 0; i < DIM_W; i++)  dim_word[i] = sr_i[MODE_W+DIM_W-1-i];
    end

    for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_wr
        assign wr_grid[g] = load_i && (cnt_i == SEG_LEN) &&
                            ((mode == MODE_ALL) || (mode == MODE_W'(g + 1)));
    end

    assign wr_dim = load_i && (cnt_i == DIM_LEN) && (mode == MODE_DIM);

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < NUM_GRIDS; g++)
            if (wr_grid[g]) st_d.seg[g] = seg_word;
        if (wr_dim) st_d.dim = dim_word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign seg_o = st_q.seg;
    assign dim_o = st_q.dim;

    // R6: storage moves only on a chip-select fall
    assert_hold_between_loads_R6: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(seg_o) && $stable(dim_o)));

    // R5: a dimming-length frame never touches segment words
    assert_dim_spares_seg_R5: assert property (@(posedge clk) disable iff (rst)
        (load_i && cnt_i == DIM_LEN) |=> $stable(seg_o));

    // R7: wrong length discards the frame
    assert_bad_length_R7: assert property (@(posedge clk) disable iff (rst)
        (load_i && cnt_i != SEG_LEN && cnt_i != DIM_LEN)
        |=> ($stable(seg_o) && $stable(dim_o)));

    // R8: unused codes discard the frame
    assert_bad_code_R8: assert property (@(posedge clk) disable iff (rst)
        (load_i && mode > MODE_DIM) |=> ($stable(seg_o) && $stable(dim_o)));

    // R4: at most one grid unless broadcasting
    assert_single_grid_R4: assert property (@(posedge clk) disable iff (rst)
        (load_i && mode != MODE_ALL) |-> $onehot0(wr_grid));
endmodule

// File: rtl/dispcmd_rx.sv
module dispcmd_rx
    import dispcmd_rx_pkg::*;
#(
    parameter int SEG_W   = 32,
    parameter int DIM_W   = 10,
    parameter int SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_i,
    input  logic             sclk_i,
    input  logic             sdata_i,
    output logic [SEG_W-1:0] grid1_seg_o,
    output logic [SEG_W-1:0] grid2_seg_o,
    output logic [SEG_W-1:0] grid3_seg_o,
    output logic [DIM_W-1:0] dim_o
);
    localparam int NUM_GRIDS = 3;
    localparam int FRAME_W   = SEG_W + MODE_W;
    localparam int CNT_W     = $clog2(FRAME_W + 2);

    logic [2:0]                      raw, synced;
    logic                            load;
    logic [CNT_W-1:0]                cnt;
    logic [FRAME_W-1:0]              sr;
    logic [NUM_GRIDS-1:0][SEG_W-1:0] seg;

    assign raw = {cs_i, sclk_i, sdata_i};

    cmd_sync #(.W(3), .STAGES(SYNC_ST)) sync_i (
        .clk (clk),
        .rst (rst),
        .din (raw),
        .dout(synced)
    );

    cmd_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shift_i (
        .clk    (clk),
        .rst    (rst),
        .cs_s   (synced[2]),
        .sclk_s (synced[1]),
        .sdata_s(synced[0]),
        .load_o (load),
        .cnt_o  (cnt),
        .sr_o   (sr)
    );

    cmd_latch_bank #(
        .SEG_W(SEG_W), .DIM_W(DIM_W), .NUM_GRIDS(NUM_GRIDS),
        .FRAME_W(FRAME_W), .CNT_W(CNT_W)
    ) bank_i (
        .clk   (clk),
        .rst   (rst),
        .load_i(load),
        .cnt_i (cnt),
        .sr_i  (sr),
        .seg_o (seg),
        .dim_o (dim_o)
    );

    assign grid1_seg_o = seg[0];
    assign grid2_seg_o = seg[1];
    assign grid3_seg_o = seg[2];
endmodule

// File: tb/dispcmd_rx_tb.sv
module dispcmd_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, sclk = 1'b0, sdata = 1'b0;
    logic [31:0] g1, g2, g3;
    logic [9:0]  dim;

    logic [31:0] e1 = '0, e2 = '0, e3 = '0;
    logic [9:0]  ed = '0;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dispcmd_rx dut_i (
        .clk(clk), .rst(rst), .cs_i(cs), .sclk_i(sclk), .sdata_i(sdata),
        .grid1_seg_o(g1), .grid2_seg_o(g2), .grid3_seg_o(g3), .dim_o(dim)
    );

    localparam int NV = 14;
    localparam int          VLEN [NV] = '{35, 35, 35, 35, 13, 13, 35, 13, 35, 35, 34, 36, 35, 14};
    localparam logic [31:0] VWORD[NV] = '{32'hA5A5_0F0F, 32'h0000_0001, 32'h8000_0000, 32'h1234_5678,
                                          32'h0000_0201, 32'h0000_03FF, 32'hFFFF_FFFF, 32'h0000_0155,
                                          32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1111_1111, 32'h2222_2222,
                                          32'h0000_0000, 32'h0000_00AA};
    localparam logic [2:0]  VMODE[NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 3'd4, 3'd1,
                                          3'd5, 3'd7, 3'd0, 3'd2, 3'd0, 3'd4};

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata = b; sclk = 1'b0; wait_clk(4);
        sclk = 1'b1; wait_clk(4);
    endtask

    // shift out len bits with chip-select high, leave it high
    task automatic shift_frame(input int len, input logic [31:0] w, input logic [2:0] m);
        cs = 1'b1; wait_clk(4);
        for (int i = 0; i < len - 3; i++) send_bit(i < 32 ? w[i] : 1'b0);
        for (int k = 0; k < 3; k++) send_bit(m[k]);
        sclk = 1'b0; wait_clk(4);
    endtask

    task automatic close_frame();
        cs = 1'b0; wait_clk(8);
    endtask

    // expected-value model taken from R3, R4, R5, R7, R8
    task automatic model(input int len, input logic [31:0] w, input logic [2:0] m);
        if (len == 35 && m == 3'd0) begin e1 = w; e2 = w; e3 = w; end
        else if (len == 35 && m == 3'd1) e1 = w;
        else if (len == 35 && m == 3'd2) e2 = w;
        else if (len == 35 && m == 3'd3) e3 = w;
        else if (len == 13 && m == 3'd4) ed = w[9:0];
    endtask

    task automatic check_all(input string req);
        checks++;
        if (g1 !== e1 || g2 !== e2 || g3 !== e3 || dim !== ed) begin
            errors++;
            $display("FAIL %s: got g1=%h g2=%h g3=%h dim=%h, expected g1=%h g2=%h g3=%h dim=%h",
                     req, g1, g2, g3, dim, e1, e2, e3, ed);
        end
    endtask

    function automatic string tag_of(input int len, input logic [2:0] m);
        if (m > 3'd4) return "R8";
        if ((m == 3'd4 && len != 13) || (m != 3'd4 && len != 35)) return "R7";
        if (m == 3'd0) return "R3";
        if (m == 3'd4) return "R5";
        return "R4";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        check_all("R1 reset state");

        for (int v = 0; v < NV; v++) begin
            shift_frame(VLEN[v], VWORD[v], VMODE[v]);
            close_frame();
            model(VLEN[v], VWORD[v], VMODE[v]);
            check_all(tag_of(VLEN[v], VMODE[v]));
        end

        // R6: full frame shifted but chip-select still high
        shift_frame(35, 32'h0F0F_7777, 3'd2);
        check_all("R6 before chip-select fall");
        close_frame();
        model(35, 32'h0F0F_7777, 3'd2);
        check_all("R6 after chip-select fall");

        // R2: shift-clock edges with chip-select low are ignored
        for (int i = 0; i < 40; i++) send_bit(1'b1);
        check_all("R2 clocks with chip-select low");
        cs = 1'b1; wait_clk(4);
        cs = 1'b0; wait_clk(8);
        check_all("R2 empty window after idle clocks");

        // R9: partial window then a clean 35-bit frame
        shift_frame(8, 32'h0000_00FF, 3'd3);
        close_frame();
        check_all("R9 partial window discarded");
        shift_frame(35, 32'h5555_AAAA, 3'd3);
        close_frame();
        model(35, 32'h5555_AAAA, 3'd3);
        check_all("R9 frame after partial window");

        // R1: reset in the middle of operation
        rst = 1'b1; wait_clk(3);
        rst = 1'b0; wait_clk(2);
        e1 = '0; e2 = '0; e3 = '0; ed = '0;
        check_all("R1 reset clears outputs");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule